// File: doc/BRIEF.md
# I2S Master Frame Timing and Serialiser

This block is the transmit timing core of an audio serial port running as clock master. An upstream clock divider supplies a one-cycle `bclk_en` pulse for every bit clock. On each such pulse the block moves through a frame made of a left half and a right half. It drives the word-select line and puts one serial data bit out on `sdata`. Outputs change only on `bclk_en`, so the pulse marks the edge of the bit clock where data changes.

The half-frame length comes from an 11-bit count, programmed as bit clocks per half minus one. An odd-length option makes the left half one bit clock longer than the right, which supports odd ratios of bit clock to sample rate. Samples are sent MSB first, in one of four sizes, in standard I2S, left-justified or DSP/PCM framing. In DSP framing the word-select line carries a frame-sync pulse, either short or long.

At the start of each frame the block captures `left_smp` and `right_smp` and pulses `smp_req`, so the source can present the next pair. Configuration is written through a two-register port. Reconfiguration takes effect only while the block is disabled.

Top module: `i2s_frame_gen`

## Requirements
- R1: After reset the block is disabled and `ws`, `sdata`, `ch_start_l`, `ch_start_r` and `smp_req` are all 0. All configuration fields are 0: I2S framing, left-low polarity, short sync, 16-bit samples, count 0, even halves.
- R2: Writing `cfg_sel`=1 sets the half count from `cfg_wdata[10:0]`. With `cfg_wdata[15]`=0 each half lasts count+1 bit clocks, down to one bit clock per half at count 0.
- R3: With `cfg_wdata[15]`=1 in the timing write, the left half lasts count+2 bit clocks and the right half lasts count+1.
- R4: Control bit `cfg_wdata[3]` (with `cfg_sel`=0) selects polarity. When 0, `ws` is low in the left half and high in the right; when 1, the levels are swapped. This applies in I2S and left-justified framing.
- R5: Control field `cfg_wdata[2:1]` selects framing: 00 I2S, 01 left-justified, 1x DSP. Each half sends its sample MSB first. The MSB goes out one bit clock after the half starts in I2S and DSP, and in the first bit clock in left-justified. Bit clocks after the last sample bit carry 0, and a half shorter than the sample truncates it.
- R6: Control field `cfg_wdata[6:5]` selects the sample size: 00 gives 16 bits, 01 gives 20, 10 gives 24 and 11 gives 32. The sample is taken from the low bits of the 32-bit input.
- R7: In DSP framing `ws` is a frame-sync. With `cfg_wdata[4]`=0 it is high only for the first bit clock of the left half; with `cfg_wdata[4]`=1 it is high for the whole left half. It is low in the right half.
- R8: `ch_start_l` and `ch_start_r` are one-cycle pulses following the `bclk_en` on which a left or right half begins. `smp_req` pulses together with `ch_start_l`, and the left and right samples used in that frame are the input values at that `bclk_en`.
- R9: While enabled, timing writes are ignored, and control writes change only the enable bit `cfg_wdata[0]`.
- R10: While disabled all outputs are 0. Clearing enable forces them to 0 on the next clock. After enabling, the first `bclk_en` starts a frame in the left half.
- R11: The full count range works: count 2047 with the odd option gives a 2049-bit-clock left half and a 2048-bit-clock right half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_en | input | 1 | One-cycle pulse per bit clock (data-change edge) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control register, 1 the timing register |
| cfg_wdata | input | 16 | Configuration write data |
| left_smp | input | 32 | Left sample, right-aligned |
| right_smp | input | 32 | Right sample, right-aligned |
| ws | output | 1 | Word select or frame sync |
| sdata | output | 1 | Serial data, MSB first |
| ch_start_l | output | 1 | Left half started |
| ch_start_r | output | 1 | Right half started |
| smp_req | output | 1 | New sample pair captured; next pair wanted |

## Verification
The bench targets the count-zero case, where a half is a single bit clock. A design with an off-by-one in the wrap would stretch or drop a half, and in I2S framing it would leak a data bit. It measures the odd-length option out to the full 2047 count; a design that put the extra bit in the wrong half, or dropped the top count bit, would give the wrong half lengths. It also writes new configuration while running, and disables in the middle of a frame; a design that accepted those writes would change length or framing mid-stream, or would restart in the right half. Each sample size is paired with halves both shorter and longer than the sample, and random samples are presented at every bit clock, so a design that captured a sample on the wrong bit clock would show it on `sdata`.

// File: rtl/i2s_frame_gen.sv
module i2s_frame_gen #(
  parameter int CNT_W = 11,
  parameter int SMP_W = 32,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_en,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [SMP_W-1:0] left_smp,
  input  logic [SMP_W-1:0] right_smp,
  output logic             ws,
  output logic             sdata,
  output logic             ch_start_l,
  output logic             ch_start_r,
  output logic             smp_req
);
  localparam int POS_W = CNT_W + 1;
  localparam int IDX_W = $clog2(SMP_W);
  localparam int SZ_W  = IDX_W + 1;

  logic             en, pol, flong, asym;
  logic [1:0]       fmt, ssz;
  logic [CNT_W-1:0] cnt;
  logic             started, half;
  logic [POS_W-1:0] bpos;
  logic [SMP_W-1:0] lbuf, rbuf;

  logic             nstart, nhalf, begin_l, begin_r;
  logic [POS_W-1:0] nbit, rel;
  logic [SZ_W-1:0]  ssize;
  logic [SMP_W-1:0] src;
  logic [IDX_W-1:0] sel;
  logic             valid, sd_nx, ws_nx;

  wire dsp   = fmt[1];
  wire ljust = (fmt == 2'b01);
  wire en_nx = (cfg_we && !cfg_sel) ? cfg_wdata[0] : en;
  wire tick  = en && bclk_en;
  wire [POS_W-1:0] last_pos = {1'b0, cnt} + POS_W'(asym && !half);

  function automatic logic [SZ_W-1:0] size_of(input logic [1:0] code);
    int v;
    case (code)
      2'd0:    v = 16;
      2'd1:    v = 20;
      2'd2:    v = 24;
      default: v = 32;
    endcase
    if (v > SMP_W) v = SMP_W;
    return SZ_W'(v);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; pol <= 1'b0; flong <= 1'b0; asym <= 1'b0;
      fmt <= 2'b00; ssz <= 2'b00; cnt <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        en <= cfg_wdata[0];
        if (!en) begin
          fmt   <= cfg_wdata[2:1];
          pol   <= cfg_wdata[3];
          flong <= cfg_wdata[4];
          ssz   <= cfg_wdata[6:5];
        end
      end else if (!en) begin
        cnt  <= cfg_wdata[CNT_W-1:0];
        asym <= cfg_wdata[CFG_W-1];
      end
    end
  end

  always_comb begin
    nstart  = started;
    nhalf   = half;
    nbit    = bpos;
    begin_l = 1'b0;
    begin_r = 1'b0;
    if (tick) begin
      if (!started) begin
        nstart  = 1'b1;
        nhalf   = 1'b0;
        nbit    = '0;
        begin_l = 1'b1;
      end else if (bpos == last_pos) begin
        nbit    = '0;
        nhalf   = !half;
        begin_l = half;
        begin_r = !half;
      end else begin
        nbit = bpos + POS_W'(1);
      end
    end
    if (!en) nstart = 1'b0;
  end

  always_comb begin
    ssize = size_of(ssz);
    rel   = nbit - POS_W'(!ljust);
    valid = (ljust || nbit != '0) && (rel < POS_W'(ssize));
    sel   = IDX_W'(POS_W'(ssize) - POS_W'(1) - rel);
    src   = nhalf ? rbuf : (begin_l ? left_smp : lbuf);
    sd_nx = valid && src[sel];
    ws_nx = dsp ? (!nhalf && (flong || nbit == '0)) : (nhalf ^ pol);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0; half <= 1'b0; bpos <= '0;
      lbuf <= '0; rbuf <= '0;
    end else begin
      started <= nstart;
      half    <= nhalf;
      bpos    <= nbit;
      if (begin_l) begin
        lbuf <= left_smp;
        rbuf <= right_smp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_nx) begin
      ws <= 1'b0; sdata <= 1'b0;
      ch_start_l <= 1'b0; ch_start_r <= 1'b0; smp_req <= 1'b0;
    end else if (tick) begin
      ws         <= ws_nx;
      sdata      <= sd_nx;
      ch_start_l <= begin_l;
      ch_start_r <= begin_r;
      smp_req    <= begin_l;
    end else begin
      ch_start_l <= 1'b0; ch_start_r <= 1'b0; smp_req <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_frame_gen_chk.sv
module i2s_frame_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_en,
  input logic cfg_we,
  input logic en,
  input logic dsp,
  input logic pol,
  input logic flong,
  input logic ws,
  input logic sdata,
  input logic ch_start_l,
  input logic ch_start_r,
  input logic smp_req
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!ws && !sdata && !ch_start_l && !ch_start_r && !smp_req));

  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bclk_en && !cfg_we) |=> ($stable(ws) && $stable(sdata)));

  p_starts_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_start_l, ch_start_r}));

  p_left_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start_l |=> !ch_start_l);

  p_req_with_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start_l |-> smp_req);

  p_left_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsp && ch_start_l) |-> (ws == pol));

  p_sync_at_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp && ch_start_l) |-> ws);

  p_sync_low_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp && ch_start_r) |-> !ws);

  p_short_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp && !flong && en && bclk_en && ws && !cfg_we) |=> !ws);
endmodule

bind i2s_frame_gen i2s_frame_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .cfg_we(cfg_we),
  .en(en), .dsp(fmt[1]), .pol(pol), .flong(flong),
  .ws(ws), .sdata(sdata), .ch_start_l(ch_start_l),
  .ch_start_r(ch_start_r), .smp_req(smp_req)
);

// File: tb/test_i2s_frame_gen.sv
`timescale 1ns/1ps
module test_i2s_frame_gen;
  logic clk = 1'b0, rst_n = 1'b0, bclk_en = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [31:0] left_smp = '0, right_smp = '0;
  logic ws, sdata, ch_start_l, ch_start_r, smp_req;

  i2s_frame_gen i_i2s_frame_gen (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .left_smp(left_smp),
    .right_smp(right_smp), .ws(ws), .sdata(sdata), .ch_start_l(ch_start_l),
    .ch_start_r(ch_start_r), .smp_req(smp_req)
  );

  always #2 clk = ~clk;

  int vectors = 0, errors = 0;
  bit m_en = 0, m_pol = 0, m_long = 0, m_asym = 0, m_started = 0;
  int m_fmt = 0, m_ssz = 0, m_cnt = 0, m_h = 0, m_b = 0;
  logic [31:0] m_lb = '0, m_rb = '0;
  logic [4:0] exp_o = '0;
  int tickno = 0, t_l = 0, t_r = 0, meas_left = -1, meas_right = -1;

  function automatic int half_len(int h);
    return (m_asym && h == 0) ? m_cnt + 2 : m_cnt + 1;
  endfunction

  function automatic int size_bits(int code);
    case (code)
      0: return 16;
      1: return 20;
      2: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic bit exp_ws(int h, int b);
    if (m_fmt >= 2) return (h == 0) && (m_long || b == 0);
    return bit'(h) ^ m_pol;
  endfunction

  function automatic bit exp_sd(int h, int b);
    int off, idx, sz;
    off = (m_fmt == 1) ? 0 : 1;
    sz  = size_bits(m_ssz);
    if (b < off) return 1'b0;
    idx = b - off;
    if (idx >= sz) return 1'b0;
    return h ? m_rb[sz-1-idx] : m_lb[sz-1-idx];
  endfunction

  task automatic compare(string tag);
    logic [4:0] got;
    got = {ws, sdata, ch_start_l, ch_start_r, smp_req};
    vectors++;
    if (got !== exp_o) begin
      errors++;
      $display("FAIL %s: {ws,sd,l,r,req} actual %b expected %b", tag, got, exp_o);
    end
  endtask

  task automatic check_val(string tag, int act, int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic tick(string tag, int gap);
    bit bl, br;
    @(negedge clk);
    bclk_en = 1'b1;
    bl = 0; br = 0;
    if (m_en) begin
      if (!m_started) begin
        m_started = 1; m_h = 0; m_b = 0; bl = 1;
      end else if (m_b == half_len(m_h) - 1) begin
        m_b = 0;
        if (m_h == 1) begin m_h = 0; bl = 1; end
        else begin m_h = 1; br = 1; end
      end else m_b++;
      if (bl) begin m_lb = left_smp; m_rb = right_smp; end
      exp_o = {exp_ws(m_h, m_b), exp_sd(m_h, m_b), bl, br, bl};
    end else exp_o = '0;
    @(negedge clk);
    bclk_en = 1'b0;
    compare(tag);
    tickno++;
    if (ch_start_r) begin meas_left = tickno - t_l; t_r = tickno; end
    if (ch_start_l) begin
      if (t_r > t_l) meas_right = tickno - t_r;
      t_l = tickno;
    end
    left_smp = $urandom; right_smp = $urandom;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      exp_o[2:0] = '0;
      compare(tag);
    end
  endtask

  task automatic wr(bit sel, logic [15:0] d, string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!sel) begin
      if (!m_en) begin
        m_fmt = int'(d[2:1]); m_pol = d[3]; m_long = d[4]; m_ssz = int'(d[6:5]);
      end
      if (d[0] && !m_en) begin t_l = tickno; t_r = tickno; meas_left = -1; meas_right = -1; end
      m_en = d[0];
      if (!m_en) begin m_started = 0; exp_o = '0; end
      else exp_o[2:0] = '0;
    end else if (!m_en) begin
      m_cnt = int'(d[10:0]); m_asym = d[15];
    end
    compare(tag);
  endtask

  function automatic logic [15:0] ctrl(bit e, int f, bit p, bit l, int s);
    return {9'd0, 2'(s), l, p, 2'(f), e};
  endfunction

  task automatic setup(int cnt, bit asym, int f, bit p, bit l, int s, string tag);
    wr(1'b0, ctrl(0, f, p, l, s), tag);
    wr(1'b1, {asym, 4'd0, 11'(cnt)}, tag);
    wr(1'b0, ctrl(1, f, p, l, s), tag);
  endtask

  task automatic run(int n, string tag, bit rgap);
    for (int i = 0; i < n; i++) tick(tag, rgap ? int'($urandom_range(0, 2)) : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    exp_o = '0;
    compare("R1 reset outputs");
    rst_n = 1'b1;
    run(3, "R10 idle while disabled", 1'b0);

    // R5 R2 R8: I2S, 16 bits in 16-clock halves
    setup(15, 0, 0, 0, 0, 0, "R5 setup");
    run(66, "R5 R8 i2s 16-bit", 1'b1);
    check_val("R2 left half", meas_left, 16);
    check_val("R2 right half", meas_right, 16);

    // R4 R6: left-justified, swapped polarity, 24 bits
    setup(23, 0, 1, 1, 0, 2, "R4 setup");
    run(75, "R4 R6 lj 24-bit", 1'b1);

    // R2 count zero: one bit clock per half
    setup(0, 0, 1, 0, 0, 0, "R2 setup");
    run(9, "R2 count zero lj", 1'b0);
    check_val("R2 zero left", meas_left, 1);
    check_val("R2 zero right", meas_right, 1);
    setup(0, 0, 0, 0, 0, 1, "R2 setup");
    run(7, "R2 count zero i2s", 1'b1);

    // R3 R6: odd-length frame, 32-bit sample truncated
    setup(17, 1, 0, 0, 0, 3, "R3 setup");
    run(60, "R3 R6 asym 32-bit", 1'b1);
    check_val("R3 left half", meas_left, 19);
    check_val("R3 right half", meas_right, 18);

    // R7: DSP short then long sync, 20-bit samples
    setup(31, 0, 2, 0, 0, 1, "R7 setup");
    run(130, "R7 dsp short", 1'b1);
    setup(31, 0, 3, 1, 1, 1, "R7 setup");
    run(130, "R7 dsp long", 1'b1);

    // R9: writes while running are ignored except enable
    wr(1'b0, ctrl(1, 1, 1, 0, 0), "R9 ctrl while on");
    wr(1'b1, 16'h8003, "R9 timing while on");
    run(130, "R9 config held", 1'b0);
    check_val("R9 left half kept", meas_left, 32);
    check_val("R9 right half kept", meas_right, 32);

    // R10: disable mid-frame, re-enable restarts on left
    setup(9, 0, 0, 0, 0, 0, "R10 setup");
    run(14, "R10 running", 1'b0);
    wr(1'b0, ctrl(0, 0, 0, 0, 0), "R10 disable clears");
    run(4, "R10 disabled", 1'b1);
    wr(1'b0, ctrl(1, 0, 0, 0, 0), "R10 enable");
    tick("R10 first tick", 0);
    check_val("R10 starts left", int'(ch_start_l), 1);
    run(25, "R10 after restart", 1'b1);

    // R11: full count with odd option
    setup(2047, 1, 0, 0, 0, 3, "R11 setup");
    run(4100, "R11 max count", 1'b0);
    check_val("R11 left half", meas_left, 2049);
    check_val("R11 right half", meas_right, 2048);

    // random configurations
    for (int k = 0; k < 25; k++) begin
      int c, f, s, fl;
      bit a, p, l;
      c = int'($urandom_range(0, 40));
      f = int'($urandom_range(0, 3));
      s = int'($urandom_range(0, 3));
      a = 1'($urandom); p = 1'($urandom); l = 1'($urandom);
      setup(c, a, f, p, l, s, "R5 R6 random setup");
      fl = 2 * (c + 1) + int'(a);
      run(3 * fl + 1, "R4 R5 R6 R7 random", 1'b1);
      check_val("R3 random left", meas_left, c + 1 + int'(a));
      check_val("R2 random right", meas_right, c + 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule